// File: doc/BRIEF.md
# Error Counter Snapshot Controller

This block keeps a bank of live counters, one per error input, that count single-cycle error pulses from the line logic. At each update point it copies every live count into a holding register that the host reads, and it clears the live counter in the same cycle. The host can therefore read a full period's totals at leisure while the next period accumulates.

The update point comes from one of two sources, chosen by a mode bit. In automatic mode a divider on the system clock produces a one-second tick. Each tick performs the copy and sets a sticky status flag. In manual mode the tick has no effect. Instead, a 0-to-1 transition of the OR of a hardware request pin and a software request bit starts one copy. The hardware pin passes through a two-flop synchroniser first. After reset the block is in automatic mode. A small register port gives write access to control and status and combinational read access to every register.

Top module: `err_snap_ctrl`

## Requirements
- R1: After reset the mode bit, the software request bit, the status flag and every holding register read 0.
- R2: With the mode bit at 0, an update occurs once every TICK_DIV clock cycles. Each update loads every holding register with the number of error pulses its input saw since the previous update, and restarts that live count.
- R3: Each automatic update sets the status flag. The flag stays set until the host writes 1 to status bit 0. If a clear and an automatic update fall in the same cycle, the flag ends up set.
- R4: Between updates the holding registers do not change, whatever the error inputs do.
- R5: With the mode bit at 1, the divider tick causes no update and does not set the flag.
- R6: With the mode bit at 1, a 0-to-1 transition of (synchronised hardware request OR software request bit) causes exactly one update. A request held high, a falling request, or a second source rising while the other is already high causes none.
- R7: A software request write is visible in the holding registers one cycle after the write edge. A hardware request rise is visible three clock edges after it is first sampled. Both delays stay under 100 ns at a 50 MHz clock.
- R8: An error pulse in the same cycle as an update is not part of the values loaded by that update. It is counted as 1 in the new period.
- R9: A live counter that reaches 2^CNT_W-1 stays there until the next update and does not wrap.
- R10: With the mode bit at 0, the hardware request and software request bit cause no update.
- R11: A manual update does not set the status flag.
- R12: The register map is as follows. Address 0 is control: bit 0 is the mode bit (1 = manual) and bit 1 is the software request bit. Both can be written and read back. Address 1 is status: bit 0 is the flag, and a write of 1 to it clears the flag. Address 2+i reads holding register i. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the timebase source |
| rst_n | input | 1 | Active-low synchronous reset |
| err_i | input | N_CNT | One-cycle error pulses, one bit per counter |
| hw_req_i | input | 1 | Asynchronous hardware update request |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 2 | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | CNT_W | Register read data, combinational |

## Verification
If the divider is off by a cycle, the distance between two flag rises differs from TICK_DIV. This shows within two periods. A broken edge detector either misses a manual update, which shows as a stale holding value within three cycles of the request, or repeats one. A repeat shows as a holding value that drops to the counts gathered while a request is held high. Wrong clear ordering at a transfer either loses or double-counts an error pulse that lands on the tick. This shows as a wrong holding value one period later. Wrong flag priority shows as a clear flag in the cycle after a clear that coincides with a tick.

// File: rtl/err_snap_ctrl.sv
`timescale 1ns/1ps
module err_snap_ctrl #(
  parameter int N_CNT    = 4,
  parameter int CNT_W    = 16,
  parameter int TICK_DIV = 50_000_000,
  parameter int ADDR_W   = $clog2(N_CNT + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CNT-1:0]  err_i,
  input  logic              hw_req_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [1:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [DIV_W-1:0] div_q;
  logic             tick;
  logic             mode_q, sw_q, flag_q;
  logic             hw_s1, hw_s2, req_d;
  logic             req_or, req_edge, auto_xfer, xfer, clr;
  logic [CNT_W-1:0] live_q [N_CNT];
  logic [CNT_W-1:0] hold_q [N_CNT];
  logic [N_CNT*CNT_W-1:0] hold_flat;

  assign tick = (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      sw_q   <= 1'b0;
    end else if (wr_en_i && wr_addr_i == ADDR_W'(0)) begin
      mode_q <= wr_data_i[0];
      sw_q   <= wr_data_i[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hw_s1 <= 1'b0;
      hw_s2 <= 1'b0;
      req_d <= 1'b0;
    end else begin
      hw_s1 <= hw_req_i;
      hw_s2 <= hw_s1;
      req_d <= req_or;
    end
  end

  assign req_or    = hw_s2 | sw_q;
  assign req_edge  = req_or & ~req_d;
  assign auto_xfer = tick & ~mode_q;
  assign xfer      = auto_xfer | (req_edge & mode_q);
  assign clr       = wr_en_i && wr_addr_i == ADDR_W'(1) && wr_data_i[0];

  always_ff @(posedge clk) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (auto_xfer) flag_q <= 1'b1;
    else if (clr)       flag_q <= 1'b0;
  end

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live_q[i] <= '0;
        hold_q[i] <= '0;
      end else if (xfer) begin
        hold_q[i] <= live_q[i];
        live_q[i] <= CNT_W'(err_i[i]);
      end else if (err_i[i] && live_q[i] != CNT_MAX) begin
        live_q[i] <= live_q[i] + CNT_W'(1);
      end
    end
    assign hold_flat[i*CNT_W +: CNT_W] = hold_q[i];
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(0)) begin
      rd_data_o[0] = mode_q;
      rd_data_o[1] = sw_q;
    end else if (rd_addr_i == ADDR_W'(1)) begin
      rd_data_o[0] = flag_q;
    end
    for (int i = 0; i < N_CNT; i++)
      if (rd_addr_i == ADDR_W'(i + 2)) rd_data_o = hold_q[i];
  end
endmodule

// File: rtl/err_snap_chk.sv
`timescale 1ns/1ps
module err_snap_chk #(
  parameter int HW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode,
  input logic          tick,
  input logic          req_edge,
  input logic          xfer,
  input logic          flag,
  input logic          clr,
  input logic [HW-1:0] hold_flat
);
  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(hold_flat));

  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !mode) |=> flag);

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(tick && !mode)) |=> !flag);

  // R11
  flag_no_self_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !(tick && !mode)) |=> !flag);

  // R5
  manual_only_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !req_edge) |-> !xfer);

  // R6
  single_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && xfer) |=> !(mode && xfer));
endmodule

bind err_snap_ctrl err_snap_chk #(.HW(N_CNT*CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode_q), .tick(tick), .req_edge(req_edge),
  .xfer(xfer), .flag(flag_q), .clr(clr), .hold_flat(hold_flat)
);

// File: tb/err_snap_ctrl_tb.sv
`timescale 1ns/1ps
module err_snap_ctrl_tb;
  localparam int N = 2, W = 4, TD = 40, AW = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] err = '0;
  logic hw_req = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  err_snap_ctrl #(.N_CNT(N), .CNT_W(W), .TICK_DIV(TD), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .err_i(err), .hw_req_i(hw_req), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = AW'(a); #1; v = int'(rd_data);
  endtask

  task automatic wr(input int a, input int d);
    wr_addr = AW'(a); wr_data = 2'(d); wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic errs(input int mask, input int n);
    for (int k = 0; k < n; k++) begin
      err = N'(mask); @(negedge clk); err = '0; @(negedge clk);
    end
  endtask

  task automatic wait_flag(output int cyc);
    int v;
    cyc = 0;
    forever begin
      rd(1, v);
      if (v[0]) break;
      @(negedge clk); cyc++;
      if (cyc > 4*TD) begin chk("R3 flag timeout", 0, 1); break; end
    end
  endtask

  task automatic t_reset;
    int v;
    for (int a = 0; a < 4; a++) begin rd(a, v); chk("R1 reset value", v, 0); end
  endtask

  task automatic t_auto;
    int c, v;
    wait_flag(c);
    wr(1, 1); rd(1, v); chk("R3 clear by write 1", v, 0);
    errs(1, 3); errs(2, 5);
    wait_flag(c); chk("R2 update period", c + 17, TD);
    rd(2, v); chk("R2 count0", v, 3);
    rd(3, v); chk("R2 count1", v, 5);
    errs(1, 4);
    rd(2, v); chk("R4 hold stable 0", v, 3);
    rd(3, v); chk("R4 hold stable 1", v, 5);
  endtask

  task automatic t_same_cycle;
    int c, v;
    wr(1, 1); wait_flag(c);
    wr(1, 1);
    repeat (TD - 2) @(negedge clk);
    err = 2'b01; @(negedge clk); err = '0;
    rd(1, v); chk("R3 flag set on tick", v, 1);
    rd(2, v); chk("R8 edge pulse excluded", v, 0);
    wr(1, 1); wait_flag(c);
    rd(2, v); chk("R8 edge pulse in new period", v, 1);
  endtask

  task automatic t_set_wins;
    int c, v;
    wr(1, 1); wait_flag(c);
    repeat (TD - 1) @(negedge clk);
    wr(1, 1);
    rd(1, v); chk("R3 set wins over clear", v, 1);
    wr(1, 1); rd(1, v); chk("R3 clear after", v, 0);
  endtask

  task automatic t_saturate;
    int c, v;
    wait_flag(c);
    wr(1, 1);
    errs(1, 18);
    wait_flag(c);
    rd(2, v); chk("R9 saturated", v, 15);
  endtask

  task automatic t_auto_ignores_manual;
    int v;
    hw_req = 1'b1;
    wr(0, 2);
    repeat (5) @(negedge clk);
    rd(2, v); chk("R10 no manual update in auto", v, 15);
    hw_req = 1'b0; wr(0, 0);
    rd(0, v); chk("R12 control readback", v, 0);
  endtask

  task automatic t_manual;
    int v;
    wr(0, 1); rd(0, v); chk("R12 mode readback", v, 1);
    wr(1, 1);
    errs(1, 4);
    repeat (100) @(negedge clk);
    rd(1, v); chk("R5 no flag in manual", v, 0);
    rd(2, v); chk("R5 no auto update", v, 15);
    wr(0, 3);
    rd(2, v); chk("R7 sw not yet", v, 15);
    @(negedge clk);
    rd(2, v); chk("R7 sw latency", v, 4);
    rd(1, v); chk("R11 manual no flag", v, 0);
    errs(1, 2); repeat (10) @(negedge clk);
    rd(2, v); chk("R6 sw held high", v, 4);
    wr(0, 1); repeat (3) @(negedge clk);
    rd(2, v); chk("R6 sw falling", v, 4);
    hw_req = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(2, v); chk("R7 hw not yet", v, 4);
    @(negedge clk);
    rd(2, v); chk("R7 hw latency", v, 2);
    errs(1, 1); repeat (10) @(negedge clk);
    rd(2, v); chk("R6 hw held high", v, 2);
    hw_req = 1'b0; repeat (5) @(negedge clk);
    hw_req = 1'b1; repeat (4) @(negedge clk);
    rd(2, v); chk("R6 second hw edge", v, 1);
    rd(1, v); chk("R11 still no flag", v, 0);
    wr(0, 3); errs(1, 2); repeat (5) @(negedge clk);
    rd(2, v); chk("R6 or already high", v, 1);
    hw_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_auto;
    t_same_cycle;
    t_set_wins;
    t_saturate;
    t_auto_ignores_manual;
    t_manual;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule